// File: doc/BRIEF.md
# External Interrupt Request Channel

This block turns one active-low external request pin into a single interrupt request line for a CPU. The pin is brought into the clock domain by a flop chain. The synchronized level is then compared against its previous sample to find falling transitions. A request latch holds each detected event until software writes an acknowledge or the CPU fetches the channel's vector.

A trigger-mode bit chooses how the latch is set. In edge mode only a high-to-low transition sets it. In edge-and-level mode a low synchronized pin also keeps setting it, so a pin that is held low requests again right after every clear. A mask bit gates only the output. A masked event still waits in the latch and reaches the CPU once the mask is lifted.

The block has a small write/read control register. It also supplies the two byte addresses of its vector (0xFFFA for the high byte, 0xFFFB for the low byte) when the CPU asks for them.

Top module: `ext_irq_channel`

## Requirements
- R1: A high-to-low transition of `irq_pin_n` sets the request latch. With the default two synchronizer stages, a pin value that is first sampled low at rising edge N shows on `irq_req` just after rising edge N+2.
- R2: In edge mode (control bit 1 = 0), a pin that stays low after its latch was cleared raises no new request until it goes high and falls again.
- R3: In edge-and-level mode (control bit 1 = 1), a low synchronized pin sets the latch. After an acknowledge or a vector fetch it therefore requests again at the very next rising edge.
- R4: With the mask (control bit 2 = 1), `irq_req` stays 0 and events are still captured. Clearing the mask makes a pending request appear on the edge that writes the mask to 0.
- R5: A register write with bit 0 = 1 clears the latch at that edge. A write with bit 0 = 0 leaves the latch unchanged.
- R6: A `vec_fetch` pulse clears the latch at that edge.
- R7: When a clear and a set condition fall on the same edge, the clear wins for that edge.
- R8: `reg_rdata` returns the trigger mode in bit 1 and the mask in bit 2. Bit 0 and all other bits read as 0. A write takes effect at the edge it is sampled on.
- R9: `vec_addr` is 0xFFFA when `vec_lo_sel` = 0 and 0xFFFB when `vec_lo_sel` = 1.
- R10: After synchronous reset, mode and mask are 0, the latch is empty and the synchronizer holds high, so `irq_req` = 0 and `reg_rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin_n | input | 1 | Asynchronous active-low external request pin |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | DATA_W | Write data: bit 0 acknowledge, bit 1 trigger mode, bit 2 mask |
| reg_rdata | output | DATA_W | Read data: mode and mask, other bits 0 |
| vec_fetch | input | 1 | CPU vector fetch strobe for this channel |
| vec_lo_sel | input | 1 | Selects the low (1) or high (0) vector byte address |
| vec_addr | output | ADDR_W | Vector byte address |
| irq_req | output | 1 | Request to the CPU, active high |

## Verification
The bench builds the channel with its defaults: two synchronizer stages, an 8-bit register and a 16-bit vector base of 0xFFFA. With two stages, the three-edge latency from pin to request can be counted exactly. The bench's pin-history queue is indexed by the same stage count. The 8-bit register leaves five reserved bits whose read-as-zero behaviour is observable, and the vector pair lands on the documented addresses.

// File: rtl/ext_irq_pkg.sv
`timescale 1ns/1ps
package ext_irq_pkg;

    // Control register bit positions
    localparam int ACK_BIT  = 0;
    localparam int MODE_BIT = 1;
    localparam int MASK_BIT = 2;
    localparam int CTRL_MSB = MASK_BIT;

    typedef enum logic {
        TRIG_EDGE       = 1'b0,
        TRIG_EDGE_LEVEL = 1'b1
    } trig_mode_e;

    typedef struct packed {
        logic       mask;
        trig_mode_e mode;
    } chan_ctrl_t;

    typedef struct packed {
        logic set_req;
        logic clr_req;
    } latch_cmd_t;

    // Set condition from current and previous synchronized samples
    function automatic logic trig_hit(logic prev_s, logic cur_s, trig_mode_e mode);
        logic fell;
        logic held_low;
        fell     = prev_s & ~cur_s;
        held_low = (mode == TRIG_EDGE_LEVEL) & ~cur_s;
        return fell | held_low;
    endfunction

endpackage

// File: rtl/irq_pin_sync.sv
`timescale 1ns/1ps
module irq_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic pin_s
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= pin_n;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[TOP-1:0], pin_n};
            end
        end
    endgenerate

    assign pin_s = chain[TOP];
endmodule

// File: rtl/irq_trigger.sv
`timescale 1ns/1ps
module irq_trigger
    import ext_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_s,
    input  trig_mode_e mode,
    input  logic       clr,
    output logic       pending
);
    logic       pin_prev;
    latch_cmd_t cmd;

    always_ff @(posedge clk) begin
        if (rst) pin_prev <= 1'b1;
        else     pin_prev <= pin_s;
    end

    always_comb begin
        cmd.set_req = trig_hit(pin_prev, pin_s, mode);
        cmd.clr_req = clr;
    end

    always_ff @(posedge clk) begin
        if (rst)              pending <= 1'b0;
        else if (cmd.clr_req) pending <= 1'b0;
        else if (cmd.set_req) pending <= 1'b1;
    end
endmodule

// File: rtl/irq_ctrl_regs.sv
`timescale 1ns/1ps
module irq_ctrl_regs
    import ext_irq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output chan_ctrl_t        ctrl,
    output logic              ack_pulse,
    output logic [DATA_W-1:0] rdata
);
    logic unused_wbits;
    assign unused_wbits = ^wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl.mode <= TRIG_EDGE;
            ctrl.mask <= 1'b0;
        end else if (wr_en) begin
            ctrl.mode <= trig_mode_e'(wdata[MODE_BIT]);
            ctrl.mask <= wdata[MASK_BIT];
        end
    end

    assign ack_pulse = wr_en & wdata[ACK_BIT];

    always_comb begin
        rdata           = '0;
        rdata[MODE_BIT] = ctrl.mode;
        rdata[MASK_BIT] = ctrl.mask;
    end
endmodule

// File: rtl/ext_irq_channel.sv
`timescale 1ns/1ps
module ext_irq_channel
    import ext_irq_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter int                DATA_W      = 8,
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] VEC_BASE    = 16'hFFFA
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_pin_n,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              vec_fetch,
    input  logic              vec_lo_sel,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              irq_req
);
    localparam logic [ADDR_W-1:0] LO_STEP = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic       pin_s;
    logic       ack_pulse;
    logic       pending;
    chan_ctrl_t ctrl;

    irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .pin_n (irq_pin_n),
        .pin_s (pin_s)
    );

    irq_ctrl_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr),
        .wdata     (reg_wdata),
        .ctrl      (ctrl),
        .ack_pulse (ack_pulse),
        .rdata     (reg_rdata)
    );

    irq_trigger u_trig (
        .clk     (clk),
        .rst     (rst),
        .pin_s   (pin_s),
        .mode    (ctrl.mode),
        .clr     (ack_pulse | vec_fetch),
        .pending (pending)
    );

    assign irq_req  = pending & ~ctrl.mask;
    assign vec_addr = vec_lo_sel ? (VEC_BASE + LO_STEP) : VEC_BASE;
endmodule

// File: rtl/ext_irq_channel_chk.sv
`timescale 1ns/1ps
module ext_irq_channel_chk #(
    parameter int DATA_W = 8,
    parameter int STAGES = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              pin_n,
    input logic              wr,
    input logic              ack_bit,
    input logic              mask_bit,
    input logic [DATA_W-1:0] rdata,
    input logic              fetch,
    input logic              irq_req
);
    localparam logic [DATA_W-1:0] LIVE_BITS =
        DATA_W'((1 << ext_irq_pkg::MODE_BIT) | (1 << ext_irq_pkg::MASK_BIT));

    // R5: write-one acknowledge removes the request on the next cycle
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (wr && ack_bit) |=> !irq_req);

    // R6: vector fetch removes the request on the next cycle
    a_r6_fetch_clears: assert property (@(posedge clk) disable iff (rst)
        fetch |=> !irq_req);

    // R4: mask keeps the output low
    a_r4_mask_blocks: assert property (@(posedge clk) disable iff (rst)
        mask_bit |-> !irq_req);

    // R8: only the mode and mask bits read back non-zero
    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (rdata & ~LIVE_BITS) == '0);

    // R1: a fresh request with the mask already open needs a low pin three samples back
    generate
        if (STAGES == 2) begin : g_lat
            a_r1_rise_needs_low: assert property (@(posedge clk) disable iff (rst)
                ($rose(irq_req) && !$past(mask_bit)) |-> !$past(pin_n, 3));
        end
    endgenerate
endmodule

bind ext_irq_channel ext_irq_channel_chk #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .pin_n    (irq_pin_n),
    .wr       (reg_wr),
    .ack_bit  (reg_wdata[ext_irq_pkg::ACK_BIT]),
    .mask_bit (reg_rdata[ext_irq_pkg::MASK_BIT]),
    .rdata    (reg_rdata),
    .fetch    (vec_fetch),
    .irq_req  (irq_req)
);

// File: tb/tb_ext_irq_channel.sv
`timescale 1ns/1ps
module tb_ext_irq_channel;
    localparam int NS     = 2;
    localparam int DW     = 8;
    localparam int AW     = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          irq_pin_n = 1'b1;
    logic          reg_wr = 1'b0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          vec_fetch = 1'b0;
    logic          vec_lo_sel = 1'b0;
    logic [AW-1:0] vec_addr;
    logic          irq_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ext_irq_channel #(.SYNC_STAGES(NS), .DATA_W(DW), .ADDR_W(AW), .VEC_BASE(16'hFFFA)) dut (
        .clk        (clk),
        .rst        (rst),
        .irq_pin_n  (irq_pin_n),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .vec_fetch  (vec_fetch),
        .vec_lo_sel (vec_lo_sel),
        .vec_addr   (vec_addr),
        .irq_req    (irq_req)
    );

    // Behavioural reference: queue of pin samples, newest at the front
    bit hist[$];
    bit m_latch = 0;
    bit m_mode  = 0;
    bit m_mask  = 0;

    initial begin
        repeat (NS + 1) hist.push_back(1'b1);
    end

    always @(posedge clk) begin : ref_model
        bit cur;
        bit old;
        bit hit;
        bit wipe;
        if (rst) begin
            m_latch = 0;
            m_mode  = 0;
            m_mask  = 0;
            hist.delete();
            repeat (NS + 1) hist.push_back(1'b1);
        end else begin
            cur  = hist[NS-1];
            old  = hist[NS];
            hit  = (old && !cur) || (m_mode && !cur);
            wipe = (reg_wr && reg_wdata[0]) || vec_fetch;
            if (wipe)     m_latch = 0;
            else if (hit) m_latch = 1;
            if (reg_wr) begin
                m_mode = reg_wdata[1];
                m_mask = reg_wdata[2];
            end
            hist.push_front(irq_pin_n);
            void'(hist.pop_back());
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare against the model on every falling edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R1 irq_req vs model", 32'(irq_req), 32'(m_latch && !m_mask));
            check("R8 reg_rdata vs model", 32'(reg_rdata), 32'({m_mask, m_mode, 1'b0}));
            check("R9 vec_addr vs model", 32'(vec_addr), vec_lo_sel ? 32'hFFFB : 32'hFFFA);
        end
    end

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic write_reg(logic [DW-1:0] d);
        reg_wr    = 1'b1;
        reg_wdata = d;
        tick();
        reg_wr    = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=complete");
            finish_run();
        end
    end

    initial begin : stim
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R10 reset state
        check("R10 irq after reset", 32'(irq_req), 0);
        check("R10 rdata after reset", 32'(reg_rdata), 0);
        // R9 vector addresses
        vec_lo_sel = 1'b0; #1;
        check("R9 high byte address", 32'(vec_addr), 32'hFFFA);
        vec_lo_sel = 1'b1; #1;
        check("R9 low byte address", 32'(vec_addr), 32'hFFFB);
        vec_lo_sel = 1'b0;

        // R1 latency
        irq_pin_n = 1'b0;
        tick(); tick();
        check("R1 not yet after two edges", 32'(irq_req), 0);
        tick();
        check("R1 request after third edge", 32'(irq_req), 1);

        // R5 acknowledge, R2 edge mode held low
        write_reg(8'h01);
        check("R5 ack clears", 32'(irq_req), 0);
        repeat (4) tick();
        check("R2 held low no re-request", 32'(irq_req), 0);

        // New edge, then write with ack=0, then vector fetch
        irq_pin_n = 1'b1;
        repeat (4) tick();
        irq_pin_n = 1'b0;
        repeat (3) tick();
        check("R1 second edge", 32'(irq_req), 1);
        write_reg(8'h00);
        check("R5 ack bit zero keeps request", 32'(irq_req), 1);
        vec_fetch = 1'b1;
        tick();
        vec_fetch = 1'b0;
        check("R6 fetch clears", 32'(irq_req), 0);
        tick();
        check("R6 stays clear in edge mode", 32'(irq_req), 0);

        // R3 level mode
        write_reg(8'h02);
        check("R8 mode reads back", 32'(reg_rdata), 32'h02);
        check("R3 not set on mode write edge", 32'(irq_req), 0);
        tick();
        check("R3 level sets latch", 32'(irq_req), 1);
        write_reg(8'h03);
        check("R5 ack in level mode", 32'(irq_req), 0);
        check("R8 ack reads zero", 32'(reg_rdata), 32'h02);
        tick();
        check("R3 re-set next clock", 32'(irq_req), 1);

        // R7 clear wins over coincident level set
        reg_wr = 1'b1; reg_wdata = 8'h03;
        for (int k = 0; k < 3; k++) begin
            tick();
            check("R7 ack beats level set", 32'(irq_req), 0);
        end
        reg_wr = 1'b0; reg_wdata = '0;
        tick();
        check("R3 level after ack stream", 32'(irq_req), 1);
        vec_fetch = 1'b1;
        for (int k = 0; k < 2; k++) begin
            tick();
            check("R7 fetch beats level set", 32'(irq_req), 0);
        end
        vec_fetch = 1'b0;
        tick();
        check("R3 level after fetch", 32'(irq_req), 1);

        // R4 mask
        write_reg(8'h00);
        check("R8 mode back to edge, latch kept", 32'(irq_req), 1);
        irq_pin_n = 1'b1;
        write_reg(8'h01);
        check("R5 clear before mask test", 32'(irq_req), 0);
        write_reg(8'h04);
        check("R8 mask reads back", 32'(reg_rdata), 32'h04);
        repeat (3) tick();
        irq_pin_n = 1'b0;
        repeat (5) tick();
        check("R4 masked output low", 32'(irq_req), 0);
        write_reg(8'h00);
        check("R4 pending appears on unmask", 32'(irq_req), 1);

        // Random traffic against the model
        for (int i = 0; i < 600; i++) begin
            if (($urandom % 4) == 0) irq_pin_n = ~irq_pin_n;
            reg_wr     = (($urandom % 8) == 0);
            reg_wdata  = DW'($urandom);
            vec_fetch  = (($urandom % 12) == 0);
            vec_lo_sel = 1'($urandom);
            tick();
        end
        reg_wr = 1'b0;
        vec_fetch = 1'b0;
        tick();
        done = 1;
        finish_run();
    end
endmodule